// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This unit sits beside the decoder of a small 8-bit processor core and turns an addressing-mode code into a 16-bit effective address. When a request is strobed, it captures the program counter and both index registers. It then fetches whatever operand bytes and pointer bytes the mode needs, one memory read per cycle, and returns the finished address together with the advanced program counter and a one-cycle done pulse. It neither executes the operation nor writes anything back.

The program counter handed in points at the first operand byte, because the opcode has already been consumed. Reads go through a single port: the unit drives a registered address and a read strobe, and the memory returns the byte on `mem_data` combinationally in the same cycle. Three wrap rules of the target architecture are kept exactly. Indexing inside page zero stays in page zero. A pointer fetched from page zero takes its second byte from page zero. The indirect jump pointer increments its low byte without carrying into the page number.

Top module: `eagen_top`

## Requirements
- R1: While reset is asserted and after it is released, `done` and `mem_rd` are 0 and `ea` and `pc_out` are 0x0000.
- R2: Mode codes are 0 implied, 1 accumulator, 2 immediate, 3 zero page, 4 zero page + X, 5 zero page + Y, 6 absolute, 7 absolute + X, 8 absolute + Y, 9 absolute indirect, 10 pre-indexed indirect (X), 11 post-indexed indirect (Y), 12 relative. Codes 0, 1 and the unused codes 13 to 15 raise `done` in the cycle after the start, with no read, `ea` = 0x0000 and `pc_out` equal to the PC given.
- R3: Immediate mode makes no read, returns the given PC as `ea` and the PC plus one as `pc_out`, with `done` in the cycle after the start.
- R4: Operand bytes are read from consecutive PC locations, low byte first. Every operand byte read advances `pc_out` by one, so absolute modes return PC+2 and zero-page, relative and indirect-indexed modes return PC+1.
- R5: Zero-page modes return the operand byte as `ea`. The indexed forms add X or Y modulo 256, so the high byte of `ea` is always 0x00.
- R6: Absolute indexed modes add X or Y to the full 16-bit operand with carry into the high byte, and 0xFFFF plus 1 gives 0x0000.
- R7: Pre-indexed indirect adds X to the operand modulo 256. It reads the pointer low byte at that zero-page location and the high byte at the next one, also modulo 256.
- R8: Post-indexed indirect reads a pointer at the operand's zero-page location, with the high-byte location wrapping in page zero. It then adds Y to the 16-bit pointer with carry.
- R9: Absolute indirect reads the target low byte at the pointer and the high byte at the pointer with only its low 8 bits incremented, so a pointer at 0x12FF takes the high byte from 0x1200.
- R10: Relative mode sign-extends the offset byte (bit 7 set is negative) and adds it to the PC after the offset byte. Page crossings carry normally.
- R11: `done` is a single-cycle pulse. It rises 1 cycle after the start for modes 0 to 2 and 13 to 15, 2 cycles after for modes 3, 4, 5 and 12, 3 cycles after for 6, 7 and 8, 4 cycles after for 10 and 11, and 5 cycles after for 9. `mem_rd` is high in every cycle between the start and `done`, and never together with `done`.
- R12: A start while an address is in progress is ignored, and the running request completes unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken when the unit is idle |
| mode | input | 4 | Addressing-mode code (see R2) |
| pc_in | input | 16 | PC pointing at the first operand byte |
| x_in | input | 8 | X index value |
| y_in | input | 8 | Y index value |
| mem_rd | output | 1 | Read strobe for this cycle |
| mem_addr | output | 16 | Read address |
| mem_data | input | 8 | Read data, valid in the same cycle as `mem_rd` |
| done | output | 1 | One-cycle completion pulse |
| ea | output | 16 | Effective address, valid with `done` |
| pc_out | output | 16 | Advanced PC, valid with `done` |

## Verification
Some properties are checked on every cycle. `done` is a one-cycle pulse and is never high together with `mem_rd`. Reads stop only when `done` rises. Immediate and implied requests finish in the next cycle with the right PC. A zero-page request reads at the given PC and ends with a page-zero address. The directed scenarios cover the rest, which depends on memory contents: the little-endian assembly, each wrap corner (0xFF pointer location, 0x12FF indirect pointer, 0xFFFF plus index), negative and page-crossing relative offsets, the exact latency per mode, and a start that is ignored mid-request.

// File: rtl/eagen_pkg.sv
package eagen_pkg;
    parameter int ADDR_W = 16;
    parameter int DATA_W = 8;

    typedef enum logic [3:0] {
        M_IMP = 4'd0,
        M_ACC = 4'd1,
        M_IMM = 4'd2,
        M_ZPG = 4'd3,
        M_ZPX = 4'd4,
        M_ZPY = 4'd5,
        M_ABS = 4'd6,
        M_ABX = 4'd7,
        M_ABY = 4'd8,
        M_IND = 4'd9,
        M_INX = 4'd10,
        M_INY = 4'd11,
        M_REL = 4'd12
    } mode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_OP0,
        S_OP1,
        S_PTR0,
        S_PTR1
    } state_e;

    typedef struct packed {
        state_e              st;
        logic [3:0]          mode;
        logic [DATA_W-1:0]   x;
        logic [DATA_W-1:0]   y;
        logic [DATA_W-1:0]   lo;
        logic [ADDR_W-1:0]   addr;
        logic [ADDR_W-1:0]   pc;
        logic [ADDR_W-1:0]   ea;
        logic                rd;
        logic                done;
    } regs_t;
endpackage

// File: rtl/eagen_idx_add.sv
module eagen_idx_add #(
    parameter int AW        = 16,
    parameter int DW        = 8,
    parameter bit PAGE_WRAP = 1'b0
) (
    input  logic [AW-1:0] base,
    input  logic [DW-1:0] idx,
    output logic [AW-1:0] sum
);
    generate
        if (PAGE_WRAP) begin : g_page
            // offset stays inside the page of the base
            logic [DW-1:0] low_sum;
            assign low_sum = base[DW-1:0] + idx;
            assign sum     = {base[AW-1:DW], low_sum};
        end else begin : g_full
            assign sum = base + AW'(idx);
        end
    endgenerate
endmodule

// File: rtl/eagen_rel_add.sv
module eagen_rel_add #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic [AW-1:0] pc,
    input  logic [DW-1:0] off,
    output logic [AW-1:0] target
);
    logic [AW-1:0] off_ext;
    assign off_ext = {{(AW-DW){off[DW-1]}}, off};
    assign target  = pc + off_ext;
endmodule

// File: rtl/eagen_top.sv
module eagen_top
    import eagen_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    mode,
    input  logic [AW-1:0] pc_in,
    input  logic [DW-1:0] x_in,
    input  logic [DW-1:0] y_in,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_data,
    output logic          done,
    output logic [AW-1:0] ea,
    output logic [AW-1:0] pc_out
);
    localparam int HI_W = AW - DW;

    regs_t r_d, r_q;

    logic [DW-1:0] zp_idx, abs_idx;
    logic [AW-1:0] zp_sum, abs_sum, ptr_next, rel_sum;

    always_comb begin
        zp_idx  = (mode_e'(r_q.mode) == M_ZPY) ? r_q.y : r_q.x;
        abs_idx = (mode_e'(r_q.mode) == M_ABY || mode_e'(r_q.mode) == M_INY) ? r_q.y : r_q.x;
    end

    eagen_idx_add #(.AW(AW), .DW(DW), .PAGE_WRAP(1'b1)) u_zp_add (
        .base ({{HI_W{1'b0}}, mem_data}),
        .idx  (zp_idx),
        .sum  (zp_sum)
    );

    eagen_idx_add #(.AW(AW), .DW(DW), .PAGE_WRAP(1'b0)) u_abs_add (
        .base ({mem_data, r_q.lo}),
        .idx  (abs_idx),
        .sum  (abs_sum)
    );

    eagen_idx_add #(.AW(AW), .DW(DW), .PAGE_WRAP(1'b1)) u_ptr_inc (
        .base (r_q.addr),
        .idx  (DW'(1)),
        .sum  (ptr_next)
    );

    eagen_rel_add #(.AW(AW), .DW(DW)) u_rel_add (
        .pc     (r_q.pc),
        .off    (mem_data),
        .target (rel_sum)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            S_IDLE: begin
                if (start) begin
                    r_d.mode = mode;
                    r_d.x    = x_in;
                    r_d.y    = y_in;
                    case (mode_e'(mode))
                        M_IMM: begin
                            r_d.ea   = pc_in;
                            r_d.pc   = pc_in + AW'(1);
                            r_d.done = 1'b1;
                        end
                        M_ZPG, M_ZPX, M_ZPY, M_ABS, M_ABX, M_ABY,
                        M_IND, M_INX, M_INY, M_REL: begin
                            r_d.st   = S_OP0;
                            r_d.rd   = 1'b1;
                            r_d.addr = pc_in;
                            r_d.pc   = pc_in + AW'(1);
                        end
                        default: begin
                            r_d.ea   = '0;
                            r_d.pc   = pc_in;
                            r_d.done = 1'b1;
                        end
                    endcase
                end
            end
            S_OP0: begin
                case (mode_e'(r_q.mode))
                    M_ZPG: begin
                        r_d.ea = {{HI_W{1'b0}}, mem_data};
                        r_d.st = S_IDLE; r_d.rd = 1'b0; r_d.done = 1'b1;
                    end
                    M_ZPX, M_ZPY: begin
                        r_d.ea = zp_sum;
                        r_d.st = S_IDLE; r_d.rd = 1'b0; r_d.done = 1'b1;
                    end
                    M_REL: begin
                        r_d.ea = rel_sum;
                        r_d.st = S_IDLE; r_d.rd = 1'b0; r_d.done = 1'b1;
                    end
                    M_INX: begin
                        r_d.addr = zp_sum;
                        r_d.st   = S_PTR0;
                    end
                    M_INY: begin
                        r_d.addr = {{HI_W{1'b0}}, mem_data};
                        r_d.st   = S_PTR0;
                    end
                    default: begin
                        r_d.lo   = mem_data;
                        r_d.addr = r_q.pc;
                        r_d.pc   = r_q.pc + AW'(1);
                        r_d.st   = S_OP1;
                    end
                endcase
            end
            S_OP1: begin
                if (mode_e'(r_q.mode) == M_IND) begin
                    r_d.addr = {mem_data, r_q.lo};
                    r_d.st   = S_PTR0;
                end else begin
                    r_d.ea = (mode_e'(r_q.mode) == M_ABS) ? {mem_data, r_q.lo} : abs_sum;
                    r_d.st = S_IDLE; r_d.rd = 1'b0; r_d.done = 1'b1;
                end
            end
            S_PTR0: begin
                r_d.lo   = mem_data;
                r_d.addr = ptr_next;
                r_d.st   = S_PTR1;
            end
            S_PTR1: begin
                r_d.ea = (mode_e'(r_q.mode) == M_INY) ? abs_sum : {mem_data, r_q.lo};
                r_d.st = S_IDLE; r_d.rd = 1'b0; r_d.done = 1'b1;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_rd   = r_q.rd;
    assign mem_addr = r_q.addr;
    assign done     = r_q.done;
    assign ea       = r_q.ea;
    assign pc_out   = r_q.pc;
endmodule

// File: rtl/eagen_chk.sv
module eagen_chk #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [3:0]    mode,
    input logic [AW-1:0] pc_in,
    input logic          mem_rd,
    input logic [AW-1:0] mem_addr,
    input logic          done,
    input logic [AW-1:0] ea,
    input logic [AW-1:0] pc_out
);
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    rd_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && mem_rd));

    // R11
    rd_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_rd) |-> done);

    // R2
    fast_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !mem_rd && (mode <= 4'd1 || mode >= 4'd13))
        |=> (done && !mem_rd && ea == '0 && pc_out == $past(pc_in)));

    // R3
    imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !mem_rd && mode == 4'd2)
        |=> (done && ea == $past(pc_in) && pc_out == AW'($past(pc_in) + AW'(1))));

    // R5
    zp_first_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !mem_rd && mode >= 4'd3 && mode <= 4'd5)
        |=> (mem_rd && mem_addr == $past(pc_in)));

    // R5
    zp_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !mem_rd && mode >= 4'd3 && mode <= 4'd5)
        |=> ##1 (done && ea[AW-1:DW] == '0));
endmodule

bind eagen_top eagen_chk #(.AW(AW), .DW(DW)) u_eagen_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .mode     (mode),
    .pc_in    (pc_in),
    .mem_rd   (mem_rd),
    .mem_addr (mem_addr),
    .done     (done),
    .ea       (ea),
    .pc_out   (pc_out)
);

// File: tb/eagen_top_test.sv
module eagen_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = 4'd0;
    logic [15:0] pc_in = 16'h0;
    logic [7:0]  x_in = 8'h0;
    logic [7:0]  y_in = 8'h0;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [7:0]  mem_data;
    logic        done;
    logic [15:0] ea;
    logic [15:0] pc_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [15:0] ov_a [16];
    logic [7:0]  ov_d [16];
    int          ov_n = 0;

    always #10 clk = ~clk;

    eagen_top uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .pc_in(pc_in), .x_in(x_in), .y_in(y_in),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_data(mem_data),
        .done(done), .ea(ea), .pc_out(pc_out)
    );

    // combinational memory: background pattern plus a few preset bytes
    always_comb begin
        mem_data = mem_addr[7:0] ^ mem_addr[15:8] ^ 8'hA5;
        for (int i = 0; i < 16; i++)
            if (i < ov_n && ov_a[i] == mem_addr) mem_data = ov_d[i];
    end

    task automatic poke(input logic [15:0] a, input logic [7:0] d);
        ov_a[ov_n] = a;
        ov_d[ov_n] = d;
        ov_n++;
    endtask

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [3:0] md, input logic [15:0] pc,
                          input logic [7:0] xv, input logic [7:0] yv,
                          input logic [15:0] e_ea, input logic [15:0] e_pc,
                          input int e_lat, input string tag);
        int lat;
        int reads;
        @(negedge clk);
        start = 1'b1; mode = md; pc_in = pc; x_in = xv; y_in = yv;
        @(negedge clk);
        start = 1'b0;
        lat = 1; reads = 0;
        while (!done && lat < 40) begin
            if (mem_rd) reads++;
            @(negedge clk);
            lat++;
        end
        chk(done == 1'b1, tag, "done", int'(done), 1);
        chk(ea == e_ea, tag, "ea", int'(ea), int'(e_ea));
        chk(pc_out == e_pc, tag, "pc_out", int'(pc_out), int'(e_pc));
        chk(lat == e_lat, "R11", "latency", lat, e_lat);
        chk(reads == e_lat - 1, "R11", "read cycles", reads, e_lat - 1);
        @(negedge clk);
        chk(done == 1'b0, "R11", "done pulse width", int'(done), 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(done == 1'b0 && mem_rd == 1'b0, "R1", "done/rd in reset", int'({done, mem_rd}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ea == 16'h0 && pc_out == 16'h0, "R1", "ea/pc after reset", int'(ea) + int'(pc_out), 0);
        chk(done == 1'b0 && mem_rd == 1'b0, "R1", "idle after reset", int'({done, mem_rd}), 0);
    endtask

    task automatic t_fast_modes;
        ov_n = 0;
        run_op(4'd0, 16'h1234, 8'h11, 8'h22, 16'h0000, 16'h1234, 1, "R2");
        run_op(4'd1, 16'h8001, 8'h11, 8'h22, 16'h0000, 16'h8001, 1, "R2");
        run_op(4'd13, 16'hBEEF, 8'h11, 8'h22, 16'h0000, 16'hBEEF, 1, "R2");
        run_op(4'd15, 16'h0042, 8'h11, 8'h22, 16'h0000, 16'h0042, 1, "R2");
        run_op(4'd2, 16'h40FF, 8'h00, 8'h00, 16'h40FF, 16'h4100, 1, "R3");
    endtask

    task automatic t_absolute;
        ov_n = 0;
        poke(16'h2000, 8'h34); poke(16'h2001, 8'h12);
        run_op(4'd6, 16'h2000, 8'h55, 8'h66, 16'h1234, 16'h2002, 3, "R4");
        ov_n = 0;
        poke(16'h2000, 8'hF0); poke(16'h2001, 8'h12);
        run_op(4'd7, 16'h2000, 8'h20, 8'h00, 16'h1310, 16'h2002, 3, "R6");
        run_op(4'd8, 16'h2000, 8'h00, 8'hFF, 16'h13EF, 16'h2002, 3, "R6");
        ov_n = 0;
        poke(16'hFFF0, 8'hFF); poke(16'hFFF1, 8'hFF);
        run_op(4'd7, 16'hFFF0, 8'h01, 8'h00, 16'h0000, 16'hFFF2, 3, "R6");
    endtask

    task automatic t_zero_page;
        ov_n = 0;
        poke(16'h3000, 8'hF0);
        run_op(4'd3, 16'h3000, 8'h20, 8'h0F, 16'h00F0, 16'h3001, 2, "R5");
        run_op(4'd4, 16'h3000, 8'h20, 8'h0F, 16'h0010, 16'h3001, 2, "R5");
        run_op(4'd5, 16'h3000, 8'h20, 8'h0F, 16'h00FF, 16'h3001, 2, "R5");
    endtask

    task automatic t_pre_indexed;
        ov_n = 0;
        poke(16'h3000, 8'hFE); poke(16'h00FF, 8'h78); poke(16'h0000, 8'h56);
        poke(16'h0100, 8'h99);
        run_op(4'd10, 16'h3000, 8'h01, 8'h00, 16'h5678, 16'h3001, 4, "R7");
        ov_n = 0;
        poke(16'h3000, 8'h10); poke(16'h0014, 8'hCD); poke(16'h0015, 8'hAB);
        run_op(4'd10, 16'h3000, 8'h04, 8'h00, 16'hABCD, 16'h3001, 4, "R7");
    endtask

    task automatic t_post_indexed;
        ov_n = 0;
        poke(16'h3000, 8'hFF); poke(16'h00FF, 8'hF0); poke(16'h0000, 8'h12);
        poke(16'h0100, 8'h99);
        run_op(4'd11, 16'h3000, 8'h00, 8'h20, 16'h1310, 16'h3001, 4, "R8");
    endtask

    task automatic t_indirect;
        ov_n = 0;
        poke(16'h2000, 8'hFF); poke(16'h2001, 8'h12);
        poke(16'h12FF, 8'hCD); poke(16'h1200, 8'hAB); poke(16'h1300, 8'h99);
        run_op(4'd9, 16'h2000, 8'h00, 8'h00, 16'hABCD, 16'h2002, 5, "R9");
        ov_n = 0;
        poke(16'h2000, 8'h80); poke(16'h2001, 8'h12);
        poke(16'h1280, 8'h11); poke(16'h1281, 8'h22);
        run_op(4'd9, 16'h2000, 8'h00, 8'h00, 16'h2211, 16'h2002, 5, "R9");
    endtask

    task automatic t_relative;
        ov_n = 0;
        poke(16'h1000, 8'h80);
        run_op(4'd12, 16'h1000, 8'h00, 8'h00, 16'h0F81, 16'h1001, 2, "R10");
        ov_n = 0;
        poke(16'h1000, 8'h7F);
        run_op(4'd12, 16'h1000, 8'h00, 8'h00, 16'h1080, 16'h1001, 2, "R10");
        ov_n = 0;
        poke(16'h10FF, 8'h05);
        run_op(4'd12, 16'h10FF, 8'h00, 8'h00, 16'h1105, 16'h1100, 2, "R10");
    endtask

    task automatic t_busy_start;
        int lat;
        ov_n = 0;
        poke(16'h2000, 8'hFF); poke(16'h2001, 8'h12);
        poke(16'h12FF, 8'hCD); poke(16'h1200, 8'hAB);
        @(negedge clk);
        start = 1'b1; mode = 4'd9; pc_in = 16'h2000;
        @(negedge clk);
        mode = 4'd0; pc_in = 16'h5555;
        lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
            if (lat == 3) start = 1'b0;
        end
        chk(lat == 5, "R12", "latency with busy start", lat, 5);
        chk(ea == 16'hABCD, "R12", "ea with busy start", int'(ea), 16'hABCD);
        chk(pc_out == 16'h2002, "R12", "pc with busy start", int'(pc_out), 16'h2002);
        @(negedge clk);
        chk(done == 1'b0 && mem_rd == 1'b0, "R12", "no second request", int'({done, mem_rd}), 0);
    endtask

    initial begin
        t_reset();
        t_fast_modes();
        t_absolute();
        t_zero_page();
        t_pre_indexed();
        t_post_indexed();
        t_indirect();
        t_relative();
        t_busy_start();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule